// File: doc/BRIEF.md
# Four-Source External Interrupt Controller

This block collects four level-sensitive interrupt request lines and presents them to a single processor context as one external-interrupt output. Software configures it through a simple register port: a small priority value per source, an enable bit field, and a priority threshold. A source counts toward the output only when it is pending, enabled and has a priority above the threshold.

The processor services interrupts with a claim/complete handshake. A read of the claim register returns the identifier of the best qualifying source and takes ownership of it: its pending bit clears and it is held in service, so it cannot pend again while the handler runs. Software keeps reading until it gets 0. For each identifier it got, it writes that identifier back to the same register, which ends service and lets the source raise a request again. Identifier 0 is reserved and means "nothing to service". The lines map to identifiers 1 to 4, and the bit fields use bits 1 to 4.

Read data is combinational. It is valid in the same cycle that the read enable is high. The side effects of a claim read take place at the clock edge that ends that cycle.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every priority, the enable field, the threshold, the pending field and all in-service flags are 0, and `ext_irq` is low.
- R2: The priority register for source i (1..4) is at byte offset 4*i and holds 3 bits, so a write keeps only `wdata[2:0]`. Offset 0 (source 0) always reads 0, and writes to it are ignored.
- R3: The pending field is at offset 0x1000, with source i at bit i. A pending bit sets at a clock edge where line i-1 of `irq_in` is high and the source is not in service. It stays set until it is claimed. Writes to the field are ignored.
- R4: The enable field is at offset 0x2000, with source i at bit i. Bits 1..4 are writable. Bit 0 and bits above 4 always read 0.
- R5: The threshold register is at offset 0x200000 and holds 3 bits, so a write keeps only `wdata[2:0]`.
- R6: A source qualifies when it is pending, it is enabled, and its priority is strictly greater than the threshold. `ext_irq` is high exactly when at least one source qualifies.
- R7: A read of the claim register at offset 0x200004 returns the ID of the qualifying source with the largest priority. On a tie the lowest ID wins. The read returns 0 when no source qualifies.
- R8: A claim read that returns a nonzero ID clears that source's pending bit and puts the source in service. A source in service does not become pending, even while its line stays high.
- R9: Writing a source ID to the claim register when that source is in service ends its service. If its line is still high, the source is pending again one clock later.
- R10: A completion write is ignored when its ID is 0, when its ID is above 4, or when the named source is not in service.
- R11: Reads of unmapped offsets return 0, and `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 22 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a claim read takes effect at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq_in | input | 4 | Interrupt lines; bit k is source k+1 |
| ext_irq | output | 1 | External interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a source that is in service while its line stays high, because a pending read then shows 0 and gives no sign of the hidden flag. The bench keeps lines asserted through a whole claim loop and then sends invalid completion writes. It shows that the flag survived by reading the pending field, which must still be 0. A valid completion must then bring the pending bit back. The sweep steps through 64 combinations of priorities, enable masks, thresholds and line patterns, including ties and sources at the threshold. It predicts the order of claimed IDs arithmetically.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NSRC   = 4,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   irq_in,
  output logic              ext_irq
);
  localparam int IDW = $clog2(NSRC + 1);
  localparam logic [ADDR_W-1:0] PEND_OFF = ADDR_W'(32'h1000);
  localparam logic [ADDR_W-1:0] EN_OFF   = ADDR_W'(32'h2000);
  localparam logic [ADDR_W-1:0] THR_OFF  = ADDR_W'(32'h200000);
  localparam logic [ADDR_W-1:0] CLM_OFF  = ADDR_W'(32'h200004);
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(4 * (NSRC + 1));

  logic [PRIO_W-1:0] prio [1:NSRC];
  logic [PRIO_W-1:0] thresh;
  logic [NSRC:1]     pend, en, insvc, qual;
  logic [IDW-1:0]    win_id;
  logic [PRIO_W-1:0] win_p;

  wire sel_prio = (addr < PRIO_END) && (addr[1:0] == 2'b00);
  wire [ADDR_W-3:0] pidx = addr[ADDR_W-1:2];
  wire claim_rd = rd_en && (addr == CLM_OFF);
  wire done_wr  = wr_en && (addr == CLM_OFF);

  always_comb begin
    win_id = '0;
    win_p  = '0;
    for (int i = 1; i <= NSRC; i++) begin
      qual[i] = pend[i] & en[i] & (prio[i] > thresh);
      if (qual[i] && prio[i] > win_p) begin
        win_id = IDW'(i);
        win_p  = prio[i];
      end
    end
  end

  assign ext_irq = |qual;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (sel_prio) begin
        for (int i = 1; i <= NSRC; i++)
          if (pidx == (ADDR_W-2)'(i)) rdata = DATA_W'(prio[i]);
      end else if (addr == PEND_OFF) rdata = DATA_W'({pend, 1'b0});
      else if (addr == EN_OFF)       rdata = DATA_W'({en, 1'b0});
      else if (addr == THR_OFF)      rdata = DATA_W'(thresh);
      else if (addr == CLM_OFF)      rdata = DATA_W'(win_id);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= NSRC; i++) prio[i] <= '0;
      thresh <= '0;
      en     <= '0;
      pend   <= '0;
      insvc  <= '0;
    end else begin
      if (wr_en && addr == THR_OFF) thresh <= wdata[PRIO_W-1:0];
      if (wr_en && addr == EN_OFF)  en <= wdata[NSRC:1];
      for (int i = 1; i <= NSRC; i++) begin
        if (wr_en && sel_prio && pidx == (ADDR_W-2)'(i)) prio[i] <= wdata[PRIO_W-1:0];
        if (claim_rd && win_id == IDW'(i)) begin
          pend[i]  <= 1'b0;
          insvc[i] <= 1'b1;
        end else begin
          pend[i] <= pend[i] | (irq_in[i-1] & ~insvc[i]);
          if (done_wr && wdata == DATA_W'(i)) insvc[i] <= 1'b0;
        end
      end
    end
  end

  assert_claim_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_rd && !ext_irq) |-> rdata == '0);
  assert_svc_not_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & insvc) == '0);
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> (pend & en) != '0);
  assert_thresh_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == THR_OFF) |=> thresh == $past(wdata[PRIO_W-1:0]));
  assert_bad_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && !rd_en && (wdata == '0 || wdata > DATA_W'(NSRC))) |=> $stable(insvc));
  for (genvar g = 1; g <= NSRC; g++) begin : g_chk
    assert_claim_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && rdata == DATA_W'(g)) |=> (insvc[g] && !pend[g]));
  end
endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [21:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] irq_in = '0;
  logic ext_irq;
  int checks = 0, errors = 0;

  ext_irq_ctrl dut (.clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata, .irq_in, .ext_irq);

  always #10 clk = ~clk;

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #2 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; irq_in = '0;
    @(negedge clk); rst_n = 1;
  endtask

  function automatic int winner(input int pm, input int em, input int p[5], input int th);
    int best = 0, bp = 0;
    for (int i = 1; i <= 4; i++)
      if (pm[i] && em[i] && p[i] > th && p[i] > bp) begin best = i; bp = p[i]; end
    return best;
  endfunction

  initial begin
    logic [31:0] v;
    int p[5];
    do_reset();
    for (int i = 0; i <= 4; i++) begin rd(22'(4*i), v); chk("R1 prio reset", v, 0); end
    rd(22'h1000, v); chk("R1 pend reset", v, 0);
    rd(22'h2000, v); chk("R1 en reset", v, 0);
    rd(22'h200000, v); chk("R1 thr reset", v, 0);
    rd(22'h200004, v); chk("R1 claim reset", v, 0);
    chk("R1 ext_irq reset", {31'd0, ext_irq}, 0);

    wr(22'h0, 32'h7); rd(22'h0, v); chk("R2 src0 prio ignored", v, 0);
    wr(22'h8, 32'hFD); rd(22'h8, v); chk("R2 prio truncated", v, 5);
    wr(22'h2000, 32'hFFFF_FFFF); rd(22'h2000, v); chk("R4 enable bits", v, 32'h1E);
    wr(22'h200000, 32'h1A); rd(22'h200000, v); chk("R5 thr truncated", v, 2);
    wr(22'h1000, 32'h1E); rd(22'h1000, v); chk("R3 pend write ignored", v, 0);
    rd(22'h100, v); chk("R11 unmapped", v, 0);
    rd(22'h3000, v); chk("R11 unmapped", v, 0);
    rd(22'h2, v); chk("R11 unaligned", v, 0);
    @(negedge clk); addr = 22'h8; #2 chk("R11 idle rdata", rdata, 0);

    do_reset();
    wr(22'h4, 1); wr(22'h2000, 32'h2);
    @(negedge clk); irq_in = 4'b0001;
    rd(22'h200004, v); chk("R7 single claim", v, 1);
    rd(22'h1000, v); chk("R8 held off while in service", v, 0);
    wr(22'h200004, 0); wr(22'h200004, 5); wr(22'h200004, 2);
    rd(22'h1000, v); chk("R10 bad completes ignored", v, 0);
    chk("R10 ext_irq low", {31'd0, ext_irq}, 0);
    wr(22'h200004, 1);
    rd(22'h1000, v); chk("R9 repend after complete", v, 2);
    chk("R6 ext_irq after repend", {31'd0, ext_irq}, 1);
    @(negedge clk); irq_in = 0;
    rd(22'h1000, v); chk("R3 pend latched after line drop", v, 2);

    for (int t = 0; t < 64; t++) begin
      int th, em, lm, pm, w, claimed;
      do_reset();
      th = t % 4; em = ((t * 5 + 3) % 16) << 1; lm = ((t * 7 + 9) % 16) << 1;
      for (int i = 1; i <= 4; i++) begin
        p[i] = (t * 3 + i * 5 + (i == 2 ? t % 2 : 0)) % 8;
        if (t % 8 == 0) p[i] = 3;
        wr(22'(4*i), 32'(p[i]));
      end
      wr(22'h200000, 32'(th)); wr(22'h2000, 32'(em));
      for (int i = 1; i <= 4; i++) begin rd(22'(4*i), v); chk("R2 prio readback", v, 32'(p[i])); end
      @(negedge clk); irq_in = 4'(lm >> 1);
      rd(22'h1000, v); chk("R3 pend sweep", v, 32'(lm));
      chk("R6 ext_irq sweep", {31'd0, ext_irq}, {31'd0, winner(lm, em, p, th) != 0});
      pm = lm; claimed = 0;
      for (int k = 0; k < 5; k++) begin
        w = winner(pm, em, p, th);
        rd(22'h200004, v); chk("R7 claim order", v, 32'(w));
        if (w == 0) break;
        pm[w] = 0; claimed[w] = 1;
      end
      rd(22'h1000, v); chk("R8 pend after claims", v, 32'(pm));
      for (int i = 1; i <= 4; i++) if (claimed[i]) wr(22'h200004, 32'(i));
      rd(22'h1000, v); chk("R9 pend after completes", v, 32'(lm));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule